// File: doc/BRIEF.md
# Free-Running Tick Counter with Snapshot Readout

This block keeps a wide up-counter that moves forward by one on each cycle where the tick-enable input is high. The counter wraps to zero after its all-ones value. At the default width of 52 bits and a 16 MHz tick, one microsecond is 16 counts. Software cannot read the running count directly. It writes an update command, polls a ready flag, and then reads a latched copy of the count as a low word and a high word. The full value is `(high << BUS_W) | low`.

A control bit decides what the external stall input does. When the bit is set, an asserted stall input freezes the counter. When the bit is clear, the stall input has no effect. The register port is a plain single-cycle bus. Every write and read completes in the cycle it is presented, so there is no back-pressure. Reads are combinational from `reg_addr` and have no side effects. No data stream crosses the block edge, so the block needs no valid/ready handshake.

Register map (`reg_addr`):

| Address | Register | Access |
|---|---|---|
| 0 | Control | read/write |
| 1 | Operation | write starts an update, read returns the ready flag |
| 2 | Snapshot low word | read only |
| 3 | Snapshot high word | read only |

Top module: `snap_counter`

## Requirements
- R1: After reset, the counter and both snapshot words are zero. The ready flag (operation register bit 1) reads 0, and the control register reads 0.
- R2: The counter adds one on each clock edge where `tick_en` is high and it is not halted. On every other edge it holds its value.
- R3: Advancing from the all-ones value (2^CNT_W − 1) gives zero.
- R4: When control bit 0 is 1, a high `stall_in` halts counting. When control bit 0 is 0, `stall_in` has no effect.
- R5: Writing address 1 with bit 0 set requests a snapshot, and the ready flag reads 0 in the next cycle. A write to address 1 with bit 0 clear changes nothing.
- R6: The snapshot holds the count as it stood in the cycle right after the request was accepted.
- R7: The ready flag stays 0 for two cycles after the request edge. It becomes 1 at the following edge, one cycle after the snapshot loads, and stays 1 until the next request.
- R8: Address 2 returns snapshot bits BUS_W−1:0. Address 3 returns snapshot bits CNT_W−1:BUS_W, and its remaining upper bits read zero.
- R9: Both snapshot words hold their values until the next request, however many ticks pass and in whatever order the words are read.
- R10: Writes to addresses 2 and 3 are ignored. Control bits above bit 0 ignore writes and read zero. Operation register bit 0 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Count enable pulse, one count per high cycle |
| stall_in | input | 1 | External stall request |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | BUS_W | Write data |
| reg_rdata | output | BUS_W | Read data for the selected register |

## Verification
The bench builds the block with CNT_W = 13 and BUS_W = 8. At this size the counter wraps after 8192 ticks, which is short enough for a snapshot sweep across the whole count range, including the wrap. The 13-bit count also spills 5 bits into the high word, so the high-word split and its three zero-padded upper bits are both checked against arithmetic expected values. Tick patterns include continuous, alternating and pseudo-random. Stall is exercised with the halt bit both set and clear, and the ready timing is checked cycle by cycle around each request.

// File: rtl/snc_pkg.sv
package snc_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_OP   = 2'd1,
    REG_LO   = 2'd2,
    REG_HI   = 2'd3
  } reg_sel_e;

  localparam int CTRL_HALT_BIT = 0;
  localparam int OP_UPDATE_BIT = 0;
  localparam int OP_READY_BIT  = 1;
endpackage

// File: rtl/snc_counter.sv
module snc_counter #(
  parameter int CNT_W = 52
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             stall_in,
  input  logic             halt_en,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic adv;
  assign adv = tick_en && !(halt_en && stall_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (adv) cnt <= cnt + ONE;
  end

  // R2: one step per enabled tick
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !stall_in && cnt != '1) |=> cnt == $past(cnt) + ONE);
  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(cnt));
  // R3: wrap to zero
  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !stall_in && cnt == '1) |=> cnt == '0);
  // R4: stall freezes only while the halt bit is set
  assert_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_en && stall_in) |=> $stable(cnt));
endmodule

// File: rtl/snc_snapshot.sv
module snc_snapshot #(
  parameter int CNT_W = 52
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] snap,
  output logic             ready
);
  logic grab;
  logic settle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grab   <= 1'b0;
      settle <= 1'b0;
      snap   <= '0;
      ready  <= 1'b0;
    end else begin
      grab   <= req;
      settle <= grab && !req;
      if (grab) snap <= cnt;
      if (req) ready <= 1'b0;
      else if (settle) ready <= 1'b1;
    end
  end

  // R5: a request drops ready in the next cycle
  assert_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !ready);
  // R7: ready rises two cycles after the load was started
  assert_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(grab, 2));
  // R9: a ready snapshot never moves
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> $stable(snap));
  assert_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !req) |=> ready);
endmodule

// File: rtl/snc_regs.sv
module snc_regs
  import snc_pkg::*;
#(
  parameter int CNT_W = 52,
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wen,
  input  logic [1:0]       addr,
  input  logic [BUS_W-1:0] wdata,
  input  logic [CNT_W-1:0] snap,
  input  logic             ready,
  output logic [BUS_W-1:0] rdata,
  output logic             halt_en,
  output logic             req
);
  localparam int HI_W = CNT_W - BUS_W;

  reg_sel_e         sel;
  logic [BUS_W-1:0] lo_word;
  logic [BUS_W-1:0] hi_word;
  logic             unused_wdata;

  assign sel          = reg_sel_e'(addr);
  assign unused_wdata = ^wdata[BUS_W-1:1];
  assign req          = wen && (sel == REG_OP) && wdata[OP_UPDATE_BIT];
  assign lo_word      = snap[BUS_W-1:0];

  generate
    if (HI_W < BUS_W) begin : g_pad
      assign hi_word = {{(BUS_W-HI_W){1'b0}}, snap[CNT_W-1:BUS_W]};
    end else begin : g_full
      assign hi_word = snap[CNT_W-1:BUS_W];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) halt_en <= 1'b0;
    else if (wen && sel == REG_CTRL) halt_en <= wdata[CTRL_HALT_BIT];
  end

  always_comb begin
    rdata = '0;
    unique case (sel)
      REG_CTRL: rdata[CTRL_HALT_BIT] = halt_en;
      REG_OP:   rdata[OP_READY_BIT]  = ready;
      REG_LO:   rdata = lo_word;
      REG_HI:   rdata = hi_word;
      default:  rdata = '0;
    endcase
  end

  // R10: only a control write can move the halt bit
  assert_ctrl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wen || sel != REG_CTRL) |=> $stable(halt_en));
  // R8: the high word tracks the snapshot top bits
  assert_hi_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == REG_HI) |-> rdata[HI_W-1:0] == snap[CNT_W-1:BUS_W]);
endmodule

// File: rtl/snap_counter.sv
module snap_counter #(
  parameter int CNT_W = 52,
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             stall_in,
  input  logic             reg_wen,
  input  logic [1:0]       reg_addr,
  input  logic [BUS_W-1:0] reg_wdata,
  output logic [BUS_W-1:0] reg_rdata
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] snap;
  logic             ready;
  logic             halt_en;
  logic             req;

  snc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .stall_in(stall_in),
    .halt_en(halt_en), .cnt(cnt)
  );

  snc_snapshot #(.CNT_W(CNT_W)) u_snap (
    .clk(clk), .rst_n(rst_n), .req(req), .cnt(cnt), .snap(snap), .ready(ready)
  );

  snc_regs #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wen(reg_wen), .addr(reg_addr),
    .wdata(reg_wdata), .snap(snap), .ready(ready), .rdata(reg_rdata),
    .halt_en(halt_en), .req(req)
  );

  // R6: the snapshot loads the count of the cycle after the request
  assert_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req) |=> snap == $past(cnt));
endmodule

// File: tb/snap_counter_tb_top.sv
module snap_counter_tb_top;
  localparam int CW  = 13;
  localparam int BW  = 8;
  localparam int MOD = 1 << CW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_en = 1'b0;
  logic          stall_in = 1'b0;
  logic          reg_wen = 1'b0;
  logic [1:0]    reg_addr = 2'd0;
  logic [BW-1:0] reg_wdata = '0;
  logic [BW-1:0] reg_rdata;

  int checks = 0;
  int fails = 0;
  int tick_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  int m_cnt;
  int exp_snap;
  logic m_halt;
  logic req_q;

  always #4 clk = ~clk;

  snap_counter #(.CNT_W(CW), .BUS_W(BW)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .stall_in(stall_in),
    .reg_wen(reg_wen), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  always @(posedge clk) begin
    #2;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (tick_mode)
      1: tick_en <= 1'b1;
      2: tick_en <= ~tick_en;
      3: tick_en <= lfsr[3];
      default: tick_en <= 1'b0;
    endcase
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0; m_halt <= 1'b0; req_q <= 1'b0; exp_snap <= 0;
    end else begin
      if (tick_en && !(m_halt && stall_in)) m_cnt <= (m_cnt + 1) % MOD;
      if (reg_wen && reg_addr == 2'd0) m_halt <= reg_wdata[0];
      req_q <= reg_wen && reg_addr == 2'd1 && reg_wdata[0];
      if (req_q) exp_snap <= m_cnt;
    end
  end

  task automatic check(input int got, input int exp, input string req);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    reg_addr = a;
    #1 v = int'(reg_rdata);
  endtask

  task automatic wr(input logic [1:0] a, input logic [BW-1:0] d);
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic snap_check();
    int v;
    wr(2'd1, 8'h01);
    rd(2'd1, v); check(v, 0, "R5 ready drops");
    @(negedge clk);
    rd(2'd1, v); check(v, 0, "R7 ready still low");
    @(negedge clk);
    rd(2'd1, v); check(v, 2, "R7 ready set");
    rd(2'd2, v); check(v, exp_snap % (1 << BW), "R6 R2 low word");
    rd(2'd3, v); check(v, exp_snap >> BW, "R8 high word");
  endtask

  initial begin
    int v;
    int prev;
    int lo0;
    int hi0;
    bit wrapped;
    wrapped = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(2'd0, v); check(v, 0, "R1 control");
    rd(2'd1, v); check(v, 0, "R1 ready");
    rd(2'd2, v); check(v, 0, "R1 low");
    rd(2'd3, v); check(v, 0, "R1 high");

    for (int mode = 1; mode <= 3; mode++) begin
      tick_mode = mode;
      repeat (10 + 15 * mode) @(negedge clk);
      snap_check();
    end

    // R9: hold across ticks, both read orders
    tick_mode = 1;
    lo0 = exp_snap % (1 << BW); hi0 = exp_snap >> BW;
    repeat (25) @(negedge clk);
    rd(2'd3, v); check(v, hi0, "R9 high first");
    rd(2'd2, v); check(v, lo0, "R9 low second");
    repeat (7) @(negedge clk);
    rd(2'd2, v); check(v, lo0, "R9 low first");
    rd(2'd3, v); check(v, hi0, "R9 high second");

    // R5 / R10: writes without effect
    wr(2'd1, 8'hFE);
    repeat (3) @(negedge clk);
    rd(2'd1, v); check(v, 2, "R5 clear-bit op write keeps ready");
    rd(2'd2, v); check(v, lo0, "R5 snapshot unchanged");
    wr(2'd2, 8'hA5); wr(2'd3, 8'h5A);
    rd(2'd2, v); check(v, lo0, "R10 low write ignored");
    rd(2'd3, v); check(v, hi0, "R10 high write ignored");
    wr(2'd0, 8'hFE);
    rd(2'd0, v); check(v, 0, "R10 control upper bits");

    // R4: stall ignored then honoured
    stall_in = 1'b1;
    repeat (20) @(negedge clk);
    snap_check();
    check(int'(exp_snap != (lo0 + (hi0 << BW))), 1, "R4 stall ignored when halt clear");
    wr(2'd0, 8'h01);
    rd(2'd0, v); check(v, 1, "R4 halt bit readback");
    snap_check();
    prev = exp_snap;
    repeat (30) @(negedge clk);
    snap_check();
    check(exp_snap, prev, "R4 frozen under stall");
    stall_in = 1'b0;
    repeat (12) @(negedge clk);
    snap_check();
    check(int'(exp_snap != prev), 1, "R4 resumes after stall");
    wr(2'd0, 8'h00);

    // R3: sweep the whole range across the wrap
    tick_mode = 1;
    prev = exp_snap;
    for (int i = 0; i < 60; i++) begin
      repeat (150) @(negedge clk);
      snap_check();
      if (exp_snap < prev) wrapped = 1'b1;
      prev = exp_snap;
    end
    check(int'(wrapped), 1, "R3 wrap observed");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule